// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block sits between an address source and an external memory controller. It splits a 30-bit byte address space into eight regions of 128 MB each and drives one active-low chip select per region. With each select it reports the data width that the selected memory uses. Seven of the regions sit at fixed 128 MB boundaries. The eighth is a relocatable window whose base and size come from configuration inputs. That window has priority over the fixed regions wherever the two overlap.

The width of region 0 cannot be programmed. It comes from two mode pins that are captured while reset is high. The same pins also choose the boot source. When they select NAND boot, the lowest 4 KB of the address space goes to an internal boot SRAM through a dedicated select output, and no external chip select is driven. An address that no enabled region claims drives no select and raises a decode-error flag.

All outputs are registered. They reflect the inputs that were present at the previous rising clock edge.

Top module: `memsel_decoder`

## Requirements
- R1: When `acc_valid` is high, bit field addr[29:27] = i (i from 0 to 6) selects fixed region i, provided `bank_en[i]` is set and no higher-priority rule applies. In that case `cs_n[i]` is low and every other bit of `cs_n` is high, one cycle after the inputs are applied.
- R2: The window (region 7) matches when addr[29:21] equals `win_base` on every bit from position k upward, where k is `win_size` clamped to 6. Its size is therefore 2 MB << k, and the bits of `win_base` below k are ignored. A match drives `cs_n[7]` low.
- R3: An enabled window match takes priority over the fixed regions and over the boot SRAM. If `bank_en[7]` is clear, the same address decodes as a fixed region.
- R4: For regions 1 to 7, `bus_width` is taken from the 2-bit field `bank_wcfg[2*(i-1)+1 : 2*(i-1)]`. The codes are 00 = 8 bits, 01 = 16 bits and 10 = 32 bits. Code 11 is reported as 10.
- R5: For region 0, `bus_width` is 01 when the captured mode is 01. For any other captured mode it is 10.
- R6: `mode_pins` is captured on every clock edge while `rst` is high. Changes to `mode_pins` after reset is released have no effect.
- R7: When the captured mode is 00 (NAND boot) and addr[29:12] is zero, `boot_sram_sel` is high, `bus_width` is 10, and no chip select is driven, whatever the value of `bank_en[0]`. Region 0 addresses at 4 KB and above still drive `cs_n[0]`.
- R8: A valid address that matches no enabled region drives all of `cs_n` high, sets `dec_err` to 1, and sets `bus_width` to 00.
- R9: One cycle after `acc_valid` is low, all chip selects are high and `dec_err`, `boot_sram_sel` and `bus_width` are all zero.
- R10: While `rst` is high, the outputs hold the idle values of R9, whatever the inputs.
- R11: At most one of the nine selects (the eight chip selects and the boot SRAM select) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens mode capture |
| addr | input | 30 | Byte address |
| acc_valid | input | 1 | Access request qualifier |
| bank_en | input | 8 | Per-region enable |
| bank_wcfg | input | 14 | Width codes for regions 1..7, two bits each |
| win_base | input | 9 | Window base in 2 MB units |
| win_size | input | 3 | Window size code, 2 MB << code, clamped at 6 |
| mode_pins | input | 2 | Boot mode / region 0 width strap |
| cs_n | output | 8 | Active-low chip selects |
| bus_width | output | 2 | Width of selected region: 00=8, 01=16, 10=32 |
| boot_sram_sel | output | 1 | Internal boot SRAM select |
| dec_err | output | 1 | Valid access matched nothing |

## Verification
Every decode result appears exactly one rising edge after the address, `acc_valid` and configuration inputs are applied. The strap, by contrast, takes effect from the last edge at which `rst` was high. The driver applies stimulus on a falling edge and queues the expected result. It then holds all inputs, configuration included, until one nanosecond after the next rising edge. The monitor pops that item two nanoseconds after the same rising edge, so each comparison sees the registered result of exactly one stimulus. The reset-state check is sampled while `rst` is still high, with a valid bank address already applied.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    // Address geometry
    localparam int ADDR_W     = 30;
    localparam int NUM_BANKS  = 8;
    localparam int BANK_SHIFT = 27;
    localparam int WIN_SHIFT  = 21;
    localparam int BOOT_SHIFT = 12;

    localparam int SEL_W     = ADDR_W - BANK_SHIFT;
    localparam int WIN_IDX_W = ADDR_W - WIN_SHIFT;
    localparam int SZ_MAX    = BANK_SHIFT - WIN_SHIFT;
    localparam int SZ_W      = $clog2(SZ_MAX + 1);
    localparam int WCFG_W    = 2 * (NUM_BANKS - 1);

    typedef enum logic [1:0] {
        BW_8   = 2'b00,
        BW_16  = 2'b01,
        BW_32  = 2'b10,
        BW_RSV = 2'b11
    } bus_width_e;

    typedef enum logic [1:0] {
        BOOT_NAND  = 2'b00,
        BOOT_NOR16 = 2'b01,
        BOOT_NOR32 = 2'b10,
        BOOT_ALT   = 2'b11
    } boot_mode_e;

    typedef struct packed {
        logic [NUM_BANKS-1:0] cs_n;
        bus_width_e           width;
        logic                 sram_sel;
        logic                 err;
    } dec_out_t;

    localparam dec_out_t DEC_IDLE = '{
        cs_n:     '1,
        width:    BW_8,
        sram_sel: 1'b0,
        err:      1'b0
    };

    // Programmed width code; the reserved code reads as 32 bits
    function automatic bus_width_e cfg_width(input logic [1:0] code);
        return (code == 2'b11) ? BW_32 : bus_width_e'(code);
    endfunction

    // Strapped width for region 0
    function automatic bus_width_e strap_width(input boot_mode_e mode);
        return (mode == BOOT_NOR16) ? BW_16 : BW_32;
    endfunction

endpackage

// File: rtl/memsel_strap.sv
module memsel_strap
    import memsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    output boot_mode_e mode_q
);

    // Transparent capture while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= boot_mode_e'(mode_pins);
        end
    end

endmodule

// File: rtl/memsel_window.sv
module memsel_window #(
    parameter int IDX_W  = 9,
    parameter int SZ_W   = 3,
    parameter int SZ_MAX = 6
) (
    input  logic [IDX_W-1:0] addr_idx,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [SZ_W-1:0]  size_code,
    output logic             hit
);

    logic [SZ_W-1:0]  sz_eff;
    logic [IDX_W-1:0] bit_ok;

    assign sz_eff = (int'(size_code) > SZ_MAX) ? SZ_W'(SZ_MAX) : size_code;

    // Bits below the window size are don't-care, the rest must agree
    for (genvar j = 0; j < IDX_W; j++) begin : g_cmp
        assign bit_ok[j] = (int'(sz_eff) > j) || (addr_idx[j] == base_idx[j]);
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/memsel_fixed.sv
module memsel_fixed #(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = 3
) (
    input  logic [SEL_W-1:0]     bank_idx,
    input  logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-2:0] hit
);

    for (genvar i = 0; i < NUM_BANKS - 1; i++) begin : g_bank
        assign hit[i] = bank_en[i] && (bank_idx == SEL_W'(i));
    end

endmodule

// File: rtl/memsel_pick.sv
module memsel_pick
    import memsel_pkg::*;
#(
    parameter int NB     = NUM_BANKS,
    parameter int WCFG_N = 2 * (NB - 1)
) (
    input  logic              valid,
    input  logic              win_en,
    input  logic              win_hit,
    input  logic              boot_low,
    input  logic [NB-2:0]     fix_hit,
    input  logic [WCFG_N-1:0] wcfg,
    input  boot_mode_e        mode,
    output dec_out_t          nxt
);

    bus_width_e bank_w [NB];

    // Width per region: strap for region 0, programmed codes for the rest
    assign bank_w[0] = strap_width(mode);
    for (genvar i = 1; i < NB; i++) begin : g_w
        assign bank_w[i] = cfg_width(wcfg[2*(i-1) +: 2]);
    end

    always_comb begin
        nxt = DEC_IDLE;
        if (valid) begin
            if (win_en && win_hit) begin
                nxt.cs_n[NB-1] = 1'b0;
                nxt.width      = bank_w[NB-1];
            end else if (mode == BOOT_NAND && boot_low) begin
                nxt.sram_sel = 1'b1;
                nxt.width    = BW_32;
            end else if (|fix_hit) begin
                for (int i = 0; i < NB - 1; i++) begin
                    if (fix_hit[i]) begin
                        nxt.cs_n[i] = 1'b0;
                        nxt.width   = bank_w[i];
                    end
                end
            end else begin
                nxt.err = 1'b1;
            end
        end
    end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 acc_valid,
    input  logic [NUM_BANKS-1:0] bank_en,
    input  logic [WCFG_W-1:0]    bank_wcfg,
    input  logic [WIN_IDX_W-1:0] win_base,
    input  logic [SZ_W-1:0]      win_size,
    input  logic [1:0]           mode_pins,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic [1:0]           bus_width,
    output logic                 boot_sram_sel,
    output logic                 dec_err
);

    boot_mode_e           mode_q;
    logic                 win_hit;
    logic [NUM_BANKS-2:0] fix_hit;
    logic                 boot_low;
    dec_out_t             dec_nxt;
    dec_out_t             dec_q;

    memsel_strap u_strap (
        .clk       (clk),
        .rst       (rst),
        .mode_pins (mode_pins),
        .mode_q    (mode_q)
    );

    memsel_window #(
        .IDX_W  (WIN_IDX_W),
        .SZ_W   (SZ_W),
        .SZ_MAX (SZ_MAX)
    ) u_window (
        .addr_idx  (addr[ADDR_W-1:WIN_SHIFT]),
        .base_idx  (win_base),
        .size_code (win_size),
        .hit       (win_hit)
    );

    memsel_fixed #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_fixed (
        .bank_idx (addr[ADDR_W-1:BANK_SHIFT]),
        .bank_en  (bank_en),
        .hit      (fix_hit)
    );

    assign boot_low = (addr[ADDR_W-1:BOOT_SHIFT] == '0);

    memsel_pick #(
        .NB (NUM_BANKS)
    ) u_pick (
        .valid    (acc_valid),
        .win_en   (bank_en[NUM_BANKS-1]),
        .win_hit  (win_hit),
        .boot_low (boot_low),
        .fix_hit  (fix_hit),
        .wcfg     (bank_wcfg),
        .mode     (mode_q),
        .nxt      (dec_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= DEC_IDLE;
        end else begin
            dec_q <= dec_nxt;
        end
    end

    assign cs_n          = dec_q.cs_n;
    assign bus_width     = dec_q.width;
    assign boot_sram_sel = dec_q.sram_sel;
    assign dec_err       = dec_q.err;

endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [29:0] addr,
    input logic        acc_valid,
    input logic [7:0]  cs_n,
    input logic [1:0]  bus_width,
    input logic        boot_sram_sel,
    input logic        dec_err
);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        ($countones(~cs_n) + 32'(boot_sram_sel)) <= 1); // R11

    AST_IDLE_AFTER_INVALID: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (&cs_n && !dec_err && !boot_sram_sel && bus_width == 2'b00)); // R9

    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (&cs_n && !boot_sram_sel && bus_width == 2'b00)); // R8

    AST_SRAM_LOW_ADDR: assert property (@(posedge clk) disable iff (rst)
        boot_sram_sel |-> ($past(addr[29:12]) == 18'd0 && bus_width == 2'b10)); // R7

    AST_BANK0_WIDTH: assert property (@(posedge clk) disable iff (rst)
        !cs_n[0] |-> (bus_width == 2'b01 || bus_width == 2'b10)); // R5

endmodule

bind memsel_decoder memsel_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr          (addr),
    .acc_valid     (acc_valid),
    .cs_n          (cs_n),
    .bus_width     (bus_width),
    .boot_sram_sel (boot_sram_sel),
    .dec_err       (dec_err)
);

// File: tb/memsel_decoder_bench.sv
`timescale 1ns/1ps
module memsel_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] addr = '0;
    logic        valid = 1'b0;
    logic [7:0]  en = 8'hFF;
    logic [13:0] wc = '0;
    logic [8:0]  b7_base = 9'h1C0;
    logic [2:0]  b7_size = 3'd6;
    logic [1:0]  om = 2'b10;
    logic [1:0]  strap = 2'b10;

    logic [7:0]  cs_n;
    logic [1:0]  bus_width;
    logic        boot_sram_sel;
    logic        dec_err;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [7:0] cs_n;
        logic [1:0] w;
        logic       s;
        logic       e;
        string      tag;
    } item_t;

    item_t q[$];
    item_t mon_e;

    always #5 clk = ~clk;

    memsel_decoder u_memsel_decoder (
        .clk           (clk),
        .rst           (rst),
        .addr          (addr),
        .acc_valid     (valid),
        .bank_en       (en),
        .bank_wcfg     (wc),
        .win_base      (b7_base),
        .win_size      (b7_size),
        .mode_pins     (om),
        .cs_n          (cs_n),
        .bus_width     (bus_width),
        .boot_sram_sel (boot_sram_sel),
        .dec_err       (dec_err)
    );

    function automatic logic [1:0] wmap(input logic [1:0] c);
        return (c == 2'b11) ? 2'b10 : c;
    endfunction

    // Expected result from the requirement text
    function automatic item_t model(input logic [29:0] a, input logic v, input string tag);
        item_t it;
        it.cs_n = 8'hFF; it.w = 2'b00; it.s = 1'b0; it.e = 1'b0; it.tag = tag;
        if (v) begin
            int   sz;
            int   bk;
            int   fi;
            logic [8:0] ai;
            bit   win;
            sz  = (b7_size > 3'd6) ? 6 : int'(b7_size);
            ai  = a[29:21];
            win = ((ai >> sz) == (b7_base >> sz));
            bk  = int'(a[29:27]);
            fi  = (bk == 0) ? 0 : bk - 1;
            if (en[7] && win) begin
                it.cs_n[7] = 1'b0; it.w = wmap(wc[13:12]);
            end else if (strap == 2'b00 && a[29:12] == 18'd0) begin
                it.s = 1'b1; it.w = 2'b10;
            end else if (bk < 7 && en[bk]) begin
                it.cs_n[bk] = 1'b0;
                it.w = (bk == 0) ? ((strap == 2'b01) ? 2'b01 : 2'b10) : wmap(wc[2*fi +: 2]);
            end else begin
                it.e = 1'b1;
            end
        end
        return it;
    endfunction

    task automatic drive(input logic [29:0] a, input logic v, input string tag);
        @(negedge clk);
        addr  = a;
        valid = v;
        q.push_back(model(a, v, tag));
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst   = 1'b1;
        om    = m;
        addr  = 30'h0800_0000;
        valid = 1'b1;
        repeat (2) @(posedge clk);
        #3;
        n_chk++;
        if (cs_n !== 8'hFF || bus_width !== 2'b00 || boot_sram_sel !== 1'b0 || dec_err !== 1'b0) begin
            n_err++;
            $display("FAIL R10 act=%h/%b/%b/%b exp=ff/00/0/0", cs_n, bus_width, boot_sram_sel, dec_err);
        end
        @(negedge clk);
        rst   = 1'b0;
        valid = 1'b0;
        strap = m;
    endtask

    // Monitor: one queued item per rising edge, sampled mid high phase
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            mon_e = q.pop_front();
            n_chk++;
            if (cs_n !== mon_e.cs_n || bus_width !== mon_e.w ||
                boot_sram_sel !== mon_e.s || dec_err !== mon_e.e) begin
                n_err++;
                $display("FAIL %s act=%h/%b/%b/%b exp=%h/%b/%b/%b", mon_e.tag,
                         cs_n, bus_width, boot_sram_sel, dec_err,
                         mon_e.cs_n, mon_e.w, mon_e.s, mon_e.e);
            end
            n_chk++;
            if (($countones(~cs_n) + 32'(boot_sram_sel)) > 1) begin
                n_err++;
                $display("FAIL R11 act=%0d selects exp<=1", $countones(~cs_n) + 32'(boot_sram_sel));
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // widths: b7=10 b6=00 b5=01 b4=11 b3=10 b2=01 b1=00
        wc = {2'b10, 2'b00, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
        do_reset(2'b10);

        drive(30'h0800_0100, 1'b1, "R1_R4_bank1");
        drive(30'h1000_0000, 1'b1, "R1_R4_bank2");
        drive(30'h1800_0040, 1'b1, "R1_R4_bank3");
        drive(30'h2000_0000, 1'b1, "R4_code11_bank4");
        drive(30'h2FFF_FFFC, 1'b1, "R1_bank5");
        drive(30'h3000_0000, 1'b1, "R1_bank6");
        drive(30'h0000_0010, 1'b1, "R5_bank0_nor32");
        drive(30'h3800_0000, 1'b1, "R2_window_default");
        drive(30'h3FFF_FFFF, 1'b1, "R2_window_top");
        drive(30'h1000_0000, 1'b0, "R9_invalid");
        drive(30'h0800_0000, 1'b1, "R9_recover");

        en = 8'hF7;
        drive(30'h1800_0000, 1'b1, "R8_bank3_disabled");
        en = 8'hFF;

        b7_size = 3'd0;
        drive(30'h3810_0000, 1'b1, "R2_window_2MB_in");
        drive(30'h3820_0000, 1'b1, "R2_R8_window_2MB_out");

        b7_base = 9'h010; b7_size = 3'd1;
        drive(30'h0230_0000, 1'b1, "R3_window_over_bank0");
        drive(30'h0240_0000, 1'b1, "R3_bank0_beyond_window");
        drive(30'h3800_0000, 1'b1, "R8_old_window_gone");
        b7_base = 9'h011;
        drive(30'h0200_0000, 1'b1, "R2_base_low_bits_ignored");
        b7_size = 3'd7;
        drive(30'h0000_0000, 1'b1, "R2_size_clamped");
        b7_size = 3'd1;
        en = 8'h7F;
        drive(30'h0200_0000, 1'b1, "R3_window_disabled");
        en = 8'hFF;

        om = 2'b01;
        drive(30'h0000_0100, 1'b1, "R6_strap_frozen");

        b7_base = 9'h1C0; b7_size = 3'd6;
        do_reset(2'b01);
        drive(30'h0000_0100, 1'b1, "R5_bank0_nor16");
        drive(30'h0000_0000, 1'b1, "R5_nor16_no_sram");

        do_reset(2'b11);
        drive(30'h0100_0000, 1'b1, "R5_bank0_mode11");

        do_reset(2'b00);
        drive(30'h0000_0FFC, 1'b1, "R7_sram_low");
        drive(30'h0000_1000, 1'b1, "R7_bank0_above_4k");
        en = 8'hFE;
        drive(30'h0000_0000, 1'b1, "R7_sram_ignores_enable");
        drive(30'h0000_2000, 1'b1, "R8_bank0_disabled_nand");
        en = 8'hFF;
        b7_base = 9'h000; b7_size = 3'd0;
        drive(30'h0000_0000, 1'b1, "R3_window_over_sram");
        drive(30'h0000_0000, 1'b0, "R9_idle_nand");

        repeat (3) @(posedge clk);
        #4;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule